// File: doc/BRIEF.md
# Accumulator and Carry Arithmetic Unit

This unit computes the data result and the new carry for the arithmetic instructions of a small 8-bit controller that works on an accumulator and a carry flag. It decodes two opcode families. The first family is the register-arithmetic group: add with carry, subtract with borrow, and exclusive-OR between the accumulator and one register. These write their result back to the selected register. The second family is the accumulator group, selected when the upper opcode nibble is `1111`. Its operations clear, set or invert the carry, step the accumulator up or down, complement it, rotate it through the carry, copy the carry into it, or apply a decimal adjust after a BCD addition.

The caller supplies the opcode, the current accumulator, the register operand and the current carry, and pulses `valid_i`. One clock later the unit presents the result, a destination code that says where to write it (nowhere, accumulator, or register), the register index, and the carry to store back. The caller owns the register file and the flag storage. Opcodes outside both families produce no write and pass the carry through unchanged.

Top module: `acc_alu`

## Requirements
- R1: Opcode `1000 rrr0` gives result = (A + R + C) mod 256 with destination register (dest code 2) and index rrr. Carry out is 1 when A + R + C exceeds 255.
- R2: Opcode `1001 rrr0` gives result = (A − R − C) mod 256 with destination register, index rrr, and carry out 1 exactly when R + C is greater than A.
- R3: Opcode `1000 rrr1` gives result A xor R with destination register and index rrr. The carry passes through unchanged.
- R4: Carry-only accumulator ops use dest code 1 (accumulator) and index 0. 0xF0 gives A=0 and C=0. 0xF1 keeps A and gives C=0. 0xFA keeps A and gives C=1. 0xF3 keeps A and inverts C.
- R5: 0xF2 gives A+1 and 0xF8 gives A−1, both mod 256. The carry becomes 1 on wrap (0xFF+1, or 0x00−1) and 0 otherwise.
- R6: 0xF4 gives the bitwise complement of A and leaves the carry unchanged.
- R7: 0xF5 shifts A left with the old C entering bit 0, and the new C is the old bit 7. 0xF6 shifts A right with the old C entering bit 7, and the new C is the old bit 0.
- R8: 0xF7 gives A = 0x00 or 0x01 according to the old carry in bit 0, and gives C=0.
- R9: 0xFB works in two steps. First it adds 0x06 when A[3:0] > 9. Then it adds 0x60 when the intermediate high nibble is > 9 or the input carry is 1. The carry out is 1 when either addition passes 0xFF, and 0 otherwise.
- R10: Accumulator-group codes 0xF9 and 0xFC–0xFF give destination accumulator with A and C unchanged.
- R11: Any opcode outside both families gives dest code 0, result 0, index 0, and the carry unchanged.
- R12: Outputs are registered. The results of a request with `valid_i`=1 appear after the next rising clock edge with `valid_o`=1. A cycle with `valid_i`=0 drives `valid_o` to 0 and holds the other outputs. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Instruction byte |
| acc_i | input | 8 | Current accumulator |
| reg_i | input | 8 | Register operand selected by the opcode |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 8 | Value to write back |
| dest_o | output | 2 | Write target: 0 none, 1 accumulator, 2 register |
| reg_idx_o | output | 3 | Register index for dest 2, otherwise 0 |
| carry_o | output | 1 | New carry flag |

## Verification
Addition and subtraction are each run with the carry set and clear, with and without wrap, and at the exact zero boundary (0x10 − 0x0F − 1). These cases separate carry-in handling from carry-out polarity. The rotates use operands whose end bits differ from the incoming carry, so a swapped direction or a dropped carry gives a visibly wrong byte. Decimal adjust is driven with a low-only correction, a high-only correction, both corrections, a carry-forced correction, and no correction, which isolates each step and the way the carry out combines them. Unassigned codes and opcodes from other families confirm that the accumulator, the carry and the destination are left alone.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_ACC  = 2'd1,
    DEST_REG  = 2'd2
  } dest_e;

  localparam logic [3:0] GRP_ADDX = 4'h8;
  localparam logic [3:0] GRP_SUB  = 4'h9;
  localparam logic [3:0] GRP_ACC  = 4'hF;

  localparam logic [3:0] FN_CLR_BOTH = 4'h0;
  localparam logic [3:0] FN_CLR_C    = 4'h1;
  localparam logic [3:0] FN_INC      = 4'h2;
  localparam logic [3:0] FN_CPL_C    = 4'h3;
  localparam logic [3:0] FN_CPL_A    = 4'h4;
  localparam logic [3:0] FN_ROL      = 4'h5;
  localparam logic [3:0] FN_ROR      = 4'h6;
  localparam logic [3:0] FN_C2A      = 4'h7;
  localparam logic [3:0] FN_DEC      = 4'h8;
  localparam logic [3:0] FN_SET_C    = 4'hA;
  localparam logic [3:0] FN_DADJ     = 4'hB;
endpackage

// File: rtl/acc_alu_regop.sv
module acc_alu_regop #(
  parameter int DATA_W = 8
) (
  input  logic              sub_i,
  input  logic              xor_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] r_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] a_ext, r_ext, c_ext, sum, dif;

  assign a_ext = {1'b0, a_i};
  assign r_ext = {1'b0, r_i};
  assign c_ext = {{DATA_W{1'b0}}, c_i};
  assign sum   = a_ext + r_ext + c_ext;
  assign dif   = a_ext - r_ext - c_ext;  // msb is the borrow

  always_comb begin
    if (xor_i) begin
      res_o = a_i ^ r_i;
      c_o   = c_i;
    end else if (sub_i) begin
      res_o = dif[DATA_W-1:0];
      c_o   = dif[DATA_W];
    end else begin
      res_o = sum[DATA_W-1:0];
      c_o   = sum[DATA_W];
    end
  end
endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam int NIB_N = DATA_W / 4;

  logic [DATA_W:0] acc;
  logic [DATA_W:0] stp;
  logic [3:0]      nib;
  logic            fix;

  // Nibbles corrected low to high; the top one is also forced by carry in.
  always_comb begin
    acc = {1'b0, a_i};
    stp = '0;
    nib = '0;
    fix = 1'b0;
    for (int i = 0; i < NIB_N; i++) begin
      nib = acc[4*i +: 4];
      fix = (nib > 4'd9) || ((i == NIB_N - 1) && c_i);
      if (fix) begin
        stp = {1'b0, acc[DATA_W-1:0]} + ({{(DATA_W-3){1'b0}}, 4'd6} << (4 * i));
        acc = {acc[DATA_W] | stp[DATA_W], stp[DATA_W-1:0]};
      end
    end
    res_o = acc[DATA_W-1:0];
    c_o   = acc[DATA_W];
  end
endmodule

// File: rtl/acc_alu_accgrp.sv
module acc_alu_accgrp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] daa_res;
  logic              daa_c;
  logic [EXT_W-1:0]  inc_x, dec_x;

  acc_alu_daa #(.DATA_W(DATA_W)) u_daa (
    .a_i  (a_i),
    .c_i  (c_i),
    .res_o(daa_res),
    .c_o  (daa_c)
  );

  assign inc_x = {1'b0, a_i} + {{DATA_W{1'b0}}, 1'b1};
  assign dec_x = {1'b0, a_i} - {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    case (fn_i)
      FN_CLR_BOTH: begin res_o = '0; c_o = 1'b0; end
      FN_CLR_C:    c_o = 1'b0;
      FN_INC:      begin res_o = inc_x[DATA_W-1:0]; c_o = inc_x[DATA_W]; end
      FN_CPL_C:    c_o = ~c_i;
      FN_CPL_A:    res_o = ~a_i;
      FN_ROL:      begin res_o = {a_i[DATA_W-2:0], c_i}; c_o = a_i[DATA_W-1]; end
      FN_ROR:      begin res_o = {c_i, a_i[DATA_W-1:1]}; c_o = a_i[0]; end
      FN_C2A:      begin res_o = {{(DATA_W-1){1'b0}}, c_i}; c_o = 1'b0; end
      FN_DEC:      begin res_o = dec_x[DATA_W-1:0]; c_o = dec_x[DATA_W]; end
      FN_SET_C:    c_o = 1'b1;
      FN_DADJ:     begin res_o = daa_res; c_o = daa_c; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [1:0]        dest_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              carry_o
);
  logic [3:0]        grp, fn;
  logic              is_reg, is_acc;
  logic [DATA_W-1:0] reg_res, acc_res, res_d;
  logic              reg_c, acc_c, c_d;
  dest_e             dest_d;
  logic [IDX_W-1:0]  idx_d;

  assign grp    = opcode_i[7:4];
  assign fn     = opcode_i[3:0];
  assign is_reg = (grp == GRP_ADDX) || (grp == GRP_SUB && !opcode_i[0]);
  assign is_acc = (grp == GRP_ACC);

  acc_alu_regop #(.DATA_W(DATA_W)) u_regop (
    .sub_i(grp == GRP_SUB),
    .xor_i(grp == GRP_ADDX && opcode_i[0]),
    .a_i  (acc_i),
    .r_i  (reg_i),
    .c_i  (carry_i),
    .res_o(reg_res),
    .c_o  (reg_c)
  );

  acc_alu_accgrp #(.DATA_W(DATA_W)) u_accgrp (
    .fn_i (fn),
    .a_i  (acc_i),
    .c_i  (carry_i),
    .res_o(acc_res),
    .c_o  (acc_c)
  );

  always_comb begin
    dest_d = DEST_NONE;
    res_d  = '0;
    c_d    = carry_i;
    idx_d  = '0;
    if (is_reg) begin
      dest_d = DEST_REG;
      res_d  = reg_res;
      c_d    = reg_c;
      idx_d  = opcode_i[IDX_W:1];
    end else if (is_acc) begin
      dest_d = DEST_ACC;
      res_d  = acc_res;
      c_d    = acc_c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      dest_o    <= DEST_NONE;
      reg_idx_o <= '0;
      carry_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        dest_o    <= dest_d;
        reg_idx_o <= idx_d;
        carry_o   <= c_d;
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        opcode_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] reg_i,
  input logic              carry_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [1:0]        dest_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              carry_o
);
  // R1
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:4] == 4'h8 && !opcode_i[0] |=>
      {carry_o, result_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(reg_i)} + {{DATA_W{1'b0}}, $past(carry_i)})
      && dest_o == 2'd2);

  // R3
  xor_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:4] == 4'h8 && opcode_i[0] |=>
      carry_o == $past(carry_i) && dest_o == 2'd2 && reg_idx_o == $past(opcode_i[IDX_W:1]));

  // R6
  cpl_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i == 8'hF4 |=> result_o == ~$past(acc_i) && carry_o == $past(carry_i));

  // R8
  carry_to_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i == 8'hF7 |=> !carry_o && result_o == {{(DATA_W-1){1'b0}}, $past(carry_i)});

  // R11
  other_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:5] == 3'b101 |=> dest_o == 2'd0 && carry_o == $past(carry_i) && result_o == '0);

  // R12
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(carry_o) && $stable(dest_o));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .opcode_i (opcode_i),
  .acc_i    (acc_i),
  .reg_i    (reg_i),
  .carry_i  (carry_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .dest_o   (dest_o),
  .reg_idx_o(reg_idx_o),
  .carry_o  (carry_o)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] reg_i = '0;
  logic       carry_i = 1'b0;
  logic       valid_o;
  logic [7:0] result_o;
  logic [1:0] dest_o;
  logic [2:0] reg_idx_o;
  logic       carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acc_alu u0 (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .acc_i, .reg_i, .carry_i,
    .valid_o, .result_o, .dest_o, .reg_idx_o, .carry_o
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, captured at posedge, sampled at next negedge
  task automatic run(string req, logic [7:0] op, logic [7:0] a, logic [7:0] r, logic c,
                     logic [7:0] e_res, logic [1:0] e_dst, logic [2:0] e_idx, logic e_c);
    @(negedge clk_i);
    opcode_i = op; acc_i = a; reg_i = r; carry_i = c; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, "valid", int'(valid_o), 1);
    check(req, "result", int'(result_o), int'(e_res));
    check(req, "dest", int'(dest_o), int'(e_dst));
    check(req, "idx", int'(reg_idx_o), int'(e_idx));
    check(req, "carry", int'(carry_o), int'(e_c));
  endtask

  task automatic t_reset();
    check("R12", "rst valid", int'(valid_o), 0);
    check("R12", "rst result", int'(result_o), 0);
    check("R12", "rst dest", int'(dest_o), 0);
    check("R12", "rst carry", int'(carry_o), 0);
  endtask

  task automatic t_add();
    run("R1", 8'h86, 8'h12, 8'h34, 1'b1, 8'h47, 2'd2, 3'd3, 1'b0);
    run("R1", 8'h80, 8'hF0, 8'h20, 1'b0, 8'h10, 2'd2, 3'd0, 1'b1);
    run("R1", 8'h8E, 8'hFF, 8'h00, 1'b1, 8'h00, 2'd2, 3'd7, 1'b1);
  endtask

  task automatic t_sub();
    run("R2", 8'h94, 8'h50, 8'h20, 1'b0, 8'h30, 2'd2, 3'd2, 1'b0);
    run("R2", 8'h94, 8'h10, 8'h10, 1'b1, 8'hFF, 2'd2, 3'd2, 1'b1);
    run("R2", 8'h94, 8'h05, 8'h09, 1'b0, 8'hFC, 2'd2, 3'd2, 1'b1);
    run("R2", 8'h94, 8'h10, 8'h0F, 1'b1, 8'h00, 2'd2, 3'd2, 1'b0);
  endtask

  task automatic t_xor();
    run("R3", 8'h8B, 8'hA5, 8'h0F, 1'b1, 8'hAA, 2'd2, 3'd5, 1'b1);
    run("R3", 8'h8B, 8'hA5, 8'h0F, 1'b0, 8'hAA, 2'd2, 3'd5, 1'b0);
  endtask

  task automatic t_carry_ops();
    run("R4", 8'hF0, 8'h77, 8'h00, 1'b1, 8'h00, 2'd1, 3'd0, 1'b0);
    run("R4", 8'hF1, 8'h77, 8'h00, 1'b1, 8'h77, 2'd1, 3'd0, 1'b0);
    run("R4", 8'hFA, 8'h33, 8'h00, 1'b0, 8'h33, 2'd1, 3'd0, 1'b1);
    run("R4", 8'hF3, 8'h33, 8'h00, 1'b1, 8'h33, 2'd1, 3'd0, 1'b0);
    run("R4", 8'hF3, 8'h33, 8'h00, 1'b0, 8'h33, 2'd1, 3'd0, 1'b1);
  endtask

  task automatic t_step();
    run("R5", 8'hF2, 8'h41, 8'h00, 1'b1, 8'h42, 2'd1, 3'd0, 1'b0);
    run("R5", 8'hF2, 8'hFF, 8'h00, 1'b0, 8'h00, 2'd1, 3'd0, 1'b1);
    run("R5", 8'hF8, 8'h00, 8'h00, 1'b0, 8'hFF, 2'd1, 3'd0, 1'b1);
    run("R5", 8'hF8, 8'h80, 8'h00, 1'b1, 8'h7F, 2'd1, 3'd0, 1'b0);
  endtask

  task automatic t_cpl();
    run("R6", 8'hF4, 8'h5A, 8'h00, 1'b1, 8'hA5, 2'd1, 3'd0, 1'b1);
    run("R6", 8'hF4, 8'h00, 8'h00, 1'b0, 8'hFF, 2'd1, 3'd0, 1'b0);
  endtask

  task automatic t_rotate();
    run("R7", 8'hF5, 8'h81, 8'h00, 1'b0, 8'h02, 2'd1, 3'd0, 1'b1);
    run("R7", 8'hF5, 8'h40, 8'h00, 1'b1, 8'h81, 2'd1, 3'd0, 1'b0);
    run("R7", 8'hF6, 8'h81, 8'h00, 1'b0, 8'h40, 2'd1, 3'd0, 1'b1);
    run("R7", 8'hF6, 8'h02, 8'h00, 1'b1, 8'h81, 2'd1, 3'd0, 1'b0);
  endtask

  task automatic t_c2a();
    run("R8", 8'hF7, 8'hEE, 8'h00, 1'b1, 8'h01, 2'd1, 3'd0, 1'b0);
    run("R8", 8'hF7, 8'hEE, 8'h00, 1'b0, 8'h00, 2'd1, 3'd0, 1'b0);
  endtask

  task automatic t_dadj();
    run("R9", 8'hFB, 8'h9A, 8'h00, 1'b0, 8'h00, 2'd1, 3'd0, 1'b1);
    run("R9", 8'hFB, 8'h15, 8'h00, 1'b1, 8'h75, 2'd1, 3'd0, 1'b0);
    run("R9", 8'hFB, 8'hFF, 8'h00, 1'b0, 8'h05, 2'd1, 3'd0, 1'b1);
    run("R9", 8'hFB, 8'h38, 8'h00, 1'b0, 8'h38, 2'd1, 3'd0, 1'b0);
    run("R9", 8'hFB, 8'h0C, 8'h00, 1'b0, 8'h12, 2'd1, 3'd0, 1'b0);
    run("R9", 8'hFB, 8'hA0, 8'h00, 1'b0, 8'h00, 2'd1, 3'd0, 1'b1);
    run("R9", 8'hFB, 8'h9F, 8'h00, 1'b0, 8'h05, 2'd1, 3'd0, 1'b1);
  endtask

  task automatic t_unassigned();
    run("R10", 8'hF9, 8'h3C, 8'h55, 1'b1, 8'h3C, 2'd1, 3'd0, 1'b1);
    run("R10", 8'hFC, 8'h3C, 8'h55, 1'b0, 8'h3C, 2'd1, 3'd0, 1'b0);
    run("R10", 8'hFF, 8'hC3, 8'h55, 1'b1, 8'hC3, 2'd1, 3'd0, 1'b1);
  endtask

  task automatic t_other();
    run("R11", 8'hA4, 8'h11, 8'h22, 1'b1, 8'h00, 2'd0, 3'd0, 1'b1);
    run("R11", 8'h97, 8'h11, 8'h22, 1'b0, 8'h00, 2'd0, 3'd0, 1'b0);
    run("R11", 8'h00, 8'hFF, 8'hFF, 1'b1, 8'h00, 2'd0, 3'd0, 1'b1);
    run("R11", 8'hE2, 8'h44, 8'h01, 1'b0, 8'h00, 2'd0, 3'd0, 1'b0);
  endtask

  task automatic t_hold();
    run("R12", 8'h86, 8'h01, 8'h02, 1'b0, 8'h03, 2'd2, 3'd3, 1'b0);
    @(negedge clk_i);
    opcode_i = 8'hF0; acc_i = 8'h99; reg_i = 8'h99; carry_i = 1'b1; valid_i = 1'b0;
    @(negedge clk_i);
    check("R12", "idle valid", int'(valid_o), 0);
    check("R12", "idle result", int'(result_o), 8'h03);
    check("R12", "idle dest", int'(dest_o), 2);
    check("R12", "idle carry", int'(carry_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_add();
    t_sub();
    t_xor();
    t_carry_ops();
    t_step();
    t_cpl();
    t_rotate();
    t_c2a();
    t_dadj();
    t_unassigned();
    t_other();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule